// File: doc/BRIEF.md
# MSI Capability and Interrupt Message Generator

This endpoint-side block holds a message-signalled interrupt capability inside a function's configuration space. Internal interrupt events are turned into posted memory write requests. Host software finds the structure through the capability list. It programs a 64-bit target address and a 16-bit payload, then sets an enable bit. From then on, each event produces one request descriptor carrying that address and payload. The descriptor is offered on a valid/ready interface to the transaction-layer logic downstream.

While the enable bit is clear, events take no part in the write path. Each event instead raises a level-sensitive legacy interrupt wire, which stays high until the local clear input is pulsed.

Configuration accesses use a dword address, a 4-bit byte-enable mask and 32-bit data. Read data is registered and appears one cycle after the read strobe. Read-only fields do not change when written. An event that arrives while a request is stalled is remembered in a single pending flag, so a burst of such events produces exactly one further request.

Top module: `msi_cap_gen`

## Requirements
- R1: After reset, the capability header dword (dword address 0x12, byte offset 0x48) reads 0x01806005. The address and data dwords read 0, `req_valid` is 0 and `irq_legacy` is 0.
- R2: In the header dword, bits [7:0] read 0x05 (capability ID) and bits [15:8] read 0x60 (next pointer). Bits 23 and 24 (control bits 7 and 8) always read 1, and every other control bit apart from the enable reads 0. Writes do not alter any of these bits.
- R3: The enable bit is header bit 16 (control bit 0). It is written only when byte enable bit 2 is set, and is read back at that position.
- R4: The low address dword (dword 0x13) is written byte by byte under the byte-enable mask. Its bits [1:0] always read 0.
- R5: The high address dword (dword 0x14) is fully writable under the byte-enable mask. In the data dword (dword 0x15), bits [15:0] are writable and bits [31:16] always read 0.
- R6: A read returns its data on `cfg_rdata` in the cycle after `cfg_rd` is sampled. Dword addresses outside 0x12..0x15 read 0.
- R7: With the enable bit set, an event sampled at a clock edge raises `req_valid` after that edge. `req_addr` is then the 64-bit programmed address and `req_data` is the 16-bit payload zero-extended to 32 bits. `req_valid` stays high until a cycle with `req_ready` high.
- R8: Any number of enabled events sampled while a request is stalled produce exactly one further request, which follows the handshake.
- R9: An enabled event sampled in the same cycle as a handshake produces a new request immediately after that edge, so `req_valid` does not drop.
- R10: With the enable bit clear, an event sets `irq_legacy` and produces no request. `irq_legacy` falls after a cycle with `irq_clr` high, except when an event and `irq_clr` fall in the same cycle; then `irq_legacy` stays high. Enabled events do not touch `irq_legacy`.
- R11: `req_addr` and `req_data` hold steady while `req_valid` is high and `req_ready` is low, even if software rewrites the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 6 | Configuration dword address |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Registered configuration read data |
| irq_evt | input | 1 | Internal interrupt event, one per cycle high |
| irq_clr | input | 1 | Clears the legacy interrupt |
| irq_legacy | output | 1 | Legacy level interrupt |
| req_valid | output | 1 | Write request offered |
| req_ready | input | 1 | Write request accepted |
| req_addr | output | 64 | Write request target address |
| req_data | output | 32 | Write request payload |

## Verification
The legacy path has a same-cycle conflict: an event and the clear pulse arrive together while the enable bit is clear. The bench drives both in one cycle and then expects the wire to be high. The message path has a similar case: an event coincides with a handshake. The bench holds `req_ready` high across two back-to-back events. A scoreboard queue then expects two separate requests, with `req_valid` still high after the first acceptance.

// File: rtl/msi_cap_pkg.sv
`timescale 1ns/1ps
package msi_cap_pkg;
  localparam int MSG_DW  = 16;
  localparam int ADDR_W  = 64;
  localparam int CFG_DW  = 32;
  localparam int CFG_BEW = CFG_DW / 8;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [MSG_DW-1:0] data;
  } msi_msg_t;
endpackage

// File: rtl/msi_cfg_regs.sv
`timescale 1ns/1ps
module msi_cfg_regs
  import msi_cap_pkg::*;
#(
  parameter int              AW       = 6,
  parameter logic [AW-1:0]   CAP_DW   = 6'h12,
  parameter logic [7:0]      CAP_ID   = 8'h05,
  parameter logic [7:0]      NEXT_PTR = 8'h60
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic               cfg_rd,
  input  logic [AW-1:0]      cfg_addr,
  input  logic [CFG_BEW-1:0] cfg_be,
  input  logic [CFG_DW-1:0]  cfg_wdata,
  output logic [CFG_DW-1:0]  cfg_rdata,
  output logic               msi_en,
  output msi_msg_t           msg
);
  localparam logic [AW-1:0] DW_HDR = CAP_DW;
  localparam logic [AW-1:0] DW_ALO = CAP_DW + AW'(1);
  localparam logic [AW-1:0] DW_AHI = CAP_DW + AW'(2);
  localparam logic [AW-1:0] DW_DAT = CAP_DW + AW'(3);
  localparam logic [15:0]   CTRL_RO = 16'h0180;

  logic              en_q, en_d;
  logic [31:0]       alo_q, alo_d;
  logic [31:0]       ahi_q, ahi_d;
  logic [MSG_DW-1:0] dat_q, dat_d;
  logic [31:0]       rdata_q, rdata_d;
  logic              wr_hdr, wr_alo, wr_ahi, wr_dat;

  assign wr_hdr = cfg_wr && (cfg_addr == DW_HDR);
  assign wr_alo = cfg_wr && (cfg_addr == DW_ALO);
  assign wr_ahi = cfg_wr && (cfg_addr == DW_AHI);
  assign wr_dat = cfg_wr && (cfg_addr == DW_DAT);

  always_comb begin
    en_d  = en_q;
    alo_d = alo_q;
    ahi_d = ahi_q;
    dat_d = dat_q;
    if (wr_hdr && cfg_be[2]) en_d = cfg_wdata[16];
    for (int b = 0; b < CFG_BEW; b++) begin
      if (wr_alo && cfg_be[b]) alo_d[8*b +: 8] = cfg_wdata[8*b +: 8];
      if (wr_ahi && cfg_be[b]) ahi_d[8*b +: 8] = cfg_wdata[8*b +: 8];
      if (wr_dat && cfg_be[b] && (b < MSG_DW/8)) dat_d[8*b +: 8] = cfg_wdata[8*b +: 8];
    end
    alo_d[1:0] = 2'b00;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (cfg_rd) begin
      unique case (cfg_addr)
        DW_HDR:  rdata_d = {CTRL_RO | {15'd0, en_q}, NEXT_PTR, CAP_ID};
        DW_ALO:  rdata_d = alo_q;
        DW_AHI:  rdata_d = ahi_q;
        DW_DAT:  rdata_d = {{(32-MSG_DW){1'b0}}, dat_q};
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      alo_q   <= '0;
      ahi_q   <= '0;
      dat_q   <= '0;
      rdata_q <= '0;
    end else begin
      en_q    <= en_d;
      alo_q   <= alo_d;
      ahi_q   <= ahi_d;
      dat_q   <= dat_d;
      rdata_q <= rdata_d;
    end
  end

  assign cfg_rdata = rdata_q;
  assign msi_en    = en_q;
  assign msg.addr  = {ahi_q, alo_q};
  assign msg.data  = dat_q;

  AST_HDR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd && (cfg_addr == DW_HDR) |=>
      (cfg_rdata[15:0] == {NEXT_PTR, CAP_ID}) && (cfg_rdata[24:23] == 2'b11) &&
      (cfg_rdata[31:25] == 7'd0) && (cfg_rdata[22:17] == 6'd0)); // R2
  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && (cfg_addr == DW_HDR) && cfg_be[2] |=> msi_en == $past(cfg_wdata[16])); // R3
  AST_ALO_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd && (cfg_addr == DW_ALO) |=> cfg_rdata[1:0] == 2'b00); // R4
endmodule

// File: rtl/msi_evt_ctrl.sv
`timescale 1ns/1ps
module msi_evt_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic msi_en,
  input  logic irq_evt,
  input  logic irq_clr,
  output logic evt_msi,
  output logic irq_legacy
);
  logic leg_q, leg_d;
  logic evt_leg;

  assign evt_msi = irq_evt & msi_en;
  assign evt_leg = irq_evt & ~msi_en;

  always_comb begin
    leg_d = leg_q;
    if (irq_clr) leg_d = 1'b0;
    if (evt_leg) leg_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) leg_q <= 1'b0;
    else        leg_q <= leg_d;
  end

  assign irq_legacy = leg_q;

  AST_LEGACY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_evt && !msi_en |=> irq_legacy); // R10
  AST_LEGACY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr && !(irq_evt && !msi_en) |=> !irq_legacy); // R10
endmodule

// File: rtl/msi_req_gen.sv
`timescale 1ns/1ps
module msi_req_gen
  import msi_cap_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     evt_msi,
  input  msi_msg_t msg_in,
  input  logic     req_ready,
  output logic     req_valid,
  output msi_msg_t msg_out
);
  logic     valid_q, valid_d;
  logic     pend_q, pend_d;
  msi_msg_t msg_q, msg_d;
  logic     hs, stall, launch;

  assign hs    = valid_q & req_ready;
  assign stall = valid_q & ~req_ready;

  always_comb begin
    launch  = 1'b0;
    if (!valid_q)   launch = evt_msi;
    else if (hs)    launch = pend_q | evt_msi;
    valid_d = launch | stall;
    pend_d  = stall & (pend_q | evt_msi);
    msg_d   = launch ? msg_in : msg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
      msg_q   <= '0;
    end else begin
      valid_q <= valid_d;
      pend_q  <= pend_d;
      msg_q   <= msg_d;
    end
  end

  assign req_valid = valid_q;
  assign msg_out   = msg_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid); // R7
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> $stable(msg_out)); // R11
  AST_PEND_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> req_valid); // R8
  AST_HS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && evt_msi |=> req_valid); // R9
endmodule

// File: rtl/msi_cap_gen.sv
`timescale 1ns/1ps
module msi_cap_gen
  import msi_cap_pkg::*;
#(
  parameter int            CFG_AW   = 6,
  parameter logic [5:0]    CAP_DW   = 6'h12,
  parameter logic [7:0]    NEXT_PTR = 8'h60
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic               cfg_rd,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [CFG_BEW-1:0] cfg_be,
  input  logic [CFG_DW-1:0]  cfg_wdata,
  output logic [CFG_DW-1:0]  cfg_rdata,
  input  logic               irq_evt,
  input  logic               irq_clr,
  output logic               irq_legacy,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [CFG_DW-1:0]  req_data
);
  logic     rst_m, rst_s;
  logic     msi_en, evt_msi;
  msi_msg_t msg_reg, msg_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  msi_cfg_regs #(
    .AW(CFG_AW), .CAP_DW(CFG_AW'(CAP_DW)), .CAP_ID(8'h05), .NEXT_PTR(NEXT_PTR)
  ) i_regs (
    .clk(clk), .rst_n(rst_s), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .msi_en(msi_en), .msg(msg_reg)
  );

  msi_evt_ctrl i_evt (
    .clk(clk), .rst_n(rst_s), .msi_en(msi_en), .irq_evt(irq_evt),
    .irq_clr(irq_clr), .evt_msi(evt_msi), .irq_legacy(irq_legacy)
  );

  msi_req_gen i_req (
    .clk(clk), .rst_n(rst_s), .evt_msi(evt_msi), .msg_in(msg_reg),
    .req_ready(req_ready), .req_valid(req_valid), .msg_out(msg_req)
  );

  assign req_addr = msg_req.addr;
  assign req_data = {{(CFG_DW-MSG_DW){1'b0}}, msg_req.data};
endmodule

// File: tb/test_msi_cap_gen.sv
`timescale 1ns/1ps
module test_msi_cap_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr, cfg_rd;
  logic [5:0]  cfg_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        irq_evt, irq_clr, irq_legacy;
  logic        req_valid, req_ready;
  logic [63:0] req_addr;
  logic [31:0] req_data;

  int checks = 0;
  int fails  = 0;
  logic [95:0] exp_q[$];
  logic [63:0] cur_addr;
  logic [15:0] cur_data;

  always #2.5 clk = ~clk;

  msi_cap_gen i_msi_cap_gen (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq_evt(irq_evt), .irq_clr(irq_clr),
    .irq_legacy(irq_legacy), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic cfg_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    tick();
    cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [5:0] a, input logic [31:0] exp, input string tag);
    tick();
    cfg_rd = 1'b1; cfg_addr = a;
    tick();
    cfg_rd = 1'b0;
    chk(cfg_rdata == exp, tag, {64'd0, cfg_rdata}, {64'd0, exp});
  endtask

  task automatic pulse(input bit evt, input bit clr);
    tick();
    irq_evt = evt; irq_clr = clr;
    tick();
    irq_evt = 1'b0; irq_clr = 1'b0;
  endtask

  task automatic push_exp();
    exp_q.push_back({cur_addr, 16'd0, cur_data});
  endtask

  // monitor: handshake happens at the next rising edge
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected request", {req_addr, req_data}, 96'd0);
      end else begin
        logic [95:0] e;
        e = exp_q.pop_front();
        chk({req_addr, req_data} == e, "R7/R11 request content", {req_addr, req_data}, e);
      end
    end
  end

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog", 96'd0, 96'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 0; cfg_rd = 0; cfg_addr = 0; cfg_be = 0; cfg_wdata = 0;
    irq_evt = 0; irq_clr = 0; req_ready = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R1 reset state
    chk(req_valid == 1'b0, "R1 req_valid", {95'd0, req_valid}, 96'd0);
    chk(irq_legacy == 1'b0, "R1 irq_legacy", {95'd0, irq_legacy}, 96'd0);
    cfg_read(6'h12, 32'h01806005, "R1 header");
    cfg_read(6'h13, 32'h0, "R1 addr low");
    cfg_read(6'h15, 32'h0, "R1 data");

    // R2 / R3 read-only fields and enable bit
    cfg_write(6'h12, 4'hF, 32'hFFFF_FFFF);
    cfg_read(6'h12, 32'h01816005, "R2 R3 header all ones");
    cfg_write(6'h12, 4'b1011, 32'h0);
    cfg_read(6'h12, 32'h01816005, "R3 enable kept without be[2]");
    cfg_write(6'h12, 4'b0100, 32'h0);
    cfg_read(6'h12, 32'h01806005, "R3 enable cleared");

    // R4 / R5 / R6
    cfg_write(6'h13, 4'hF, 32'hFEE0_F00F);
    cfg_read(6'h13, 32'hFEE0_F00C, "R4 low bits zero");
    cfg_write(6'h13, 4'b0001, 32'h0000_0033);
    cfg_read(6'h13, 32'hFEE0_F030, "R4 byte enable");
    cfg_write(6'h13, 4'hF, 32'hFEE0_F00C);
    cfg_write(6'h14, 4'b0010, 32'h0000_5A00);
    cfg_read(6'h14, 32'h0000_5A00, "R5 addr high byte");
    cfg_write(6'h15, 4'hF, 32'hABCD_41B1);
    cfg_read(6'h15, 32'h0000_41B1, "R5 data upper zero");
    cfg_read(6'h10, 32'h0, "R6 unmapped reads zero");
    cur_addr = 64'h0000_5A00_FEE0_F00C;
    cur_data = 16'h41B1;

    // R10 legacy path while disabled
    pulse(1'b1, 1'b0);
    chk(irq_legacy == 1'b1, "R10 legacy set", {95'd0, irq_legacy}, 96'd1);
    chk(req_valid == 1'b0, "R10 no request", {95'd0, req_valid}, 96'd0);
    pulse(1'b0, 1'b1);
    chk(irq_legacy == 1'b0, "R10 legacy cleared", {95'd0, irq_legacy}, 96'd0);
    pulse(1'b1, 1'b1);
    chk(irq_legacy == 1'b1, "R10 event wins over clear", {95'd0, irq_legacy}, 96'd1);
    pulse(1'b0, 1'b1);

    // R7 single request
    cfg_write(6'h12, 4'b0100, 32'h0001_0000);
    req_ready = 1'b1;
    push_exp();
    pulse(1'b1, 1'b0);
    chk(req_valid == 1'b1, "R7 valid after event", {95'd0, req_valid}, 96'd1);
    chk(irq_legacy == 1'b0, "R10 enabled event leaves legacy", {95'd0, irq_legacy}, 96'd0);
    repeat (3) tick();
    chk(req_valid == 1'b0, "R7 valid drops after handshake", {95'd0, req_valid}, 96'd0);

    // R8 coalescing while stalled
    req_ready = 1'b0;
    push_exp();
    pulse(1'b1, 1'b0);
    push_exp();
    for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0);
    repeat (4) tick();
    chk(req_valid == 1'b1, "R7 valid held while stalled", {95'd0, req_valid}, 96'd1);
    req_ready = 1'b1;
    repeat (6) tick();
    chk(req_valid == 1'b0 && exp_q.size() == 0, "R8 exactly one extra request",
        {64'd0, 31'd0, req_valid, exp_q.size()}, 96'd0);

    // R9 event on handshake cycle
    push_exp(); push_exp();
    tick();
    irq_evt = 1'b1;
    tick();
    tick();
    irq_evt = 1'b0;
    chk(req_valid == 1'b1, "R9 valid stays after handshake with event", {95'd0, req_valid}, 96'd1);
    repeat (4) tick();
    chk(exp_q.size() == 0, "R9 two requests", {64'd0, exp_q.size()}, 96'd0);

    // R11 stability under reprogramming
    req_ready = 1'b0;
    push_exp();
    pulse(1'b1, 1'b0);
    cfg_write(6'h13, 4'hF, 32'h1234_5678);
    cfg_write(6'h15, 4'hF, 32'h0000_7777);
    tick();
    chk(req_addr == cur_addr && req_data == {16'd0, cur_data}, "R11 held content",
        {req_addr, req_data}, {cur_addr, 16'd0, cur_data});
    req_ready = 1'b1;
    repeat (4) tick();
    chk(exp_q.size() == 0 && req_valid == 1'b0, "R11 drained",
        {64'd0, 31'd0, req_valid, exp_q.size()}, 96'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule